// File: doc/BRIEF.md
# DSP Address Generation Unit

This unit produces the data-memory address for each access of a filter or FFT loop, so the arithmetic datapath never spends a cycle on pointer arithmetic. Software loads a base, a buffer length, a signed step, a walking mode and an iteration count in one configuration write. After that, each accepted request gets the current address, and the internal offset moves on by one of three rules. The rules are plain post-increment, wrap-around inside a circular buffer, and reverse-carry stepping that visits FFT samples in bit-reversed order.

An iteration counter runs beside the pointer and marks the address that belongs to the final pass of the loop. A loop body, such as a multiply-accumulate, can therefore close without a branch. At the end of the count the unit either restarts the count and keeps going, or stops and deasserts ready until it is configured again.

Top module: `dsp_agu`

## Requirements
- R1: While reset is asserted, and at any time it is asserted asynchronously, `req_ready` and `last_iter` are 0 and `addr_out` is 0.
- R2: In a cycle with `cfg_we`=1, `req_ready` and `last_iter` are 0. From the next cycle, `addr_out` equals the loaded base, because the offset restarts at 0.
- R3: Mode 0 (linear) and mode 3, which behaves the same way: each accepted request adds the signed step to the address, modulo 2^AW.
- R4: Mode 1 (circular) with a non-negative step: if offset+step is at least the length, the new offset is offset+step−length.
- R5: Mode 1 with a negative step: if offset+step is below 0, the new offset is offset+step+length. This keeps the address at or above the base.
- R6: Mode 2 (bit-reversed): the offset advances by adding length/2 with the carry running from MSB toward LSB. The step is ignored. For length 8 the offsets are 0,4,2,6,1,5,3,7 and then 0 again.
- R7: The offset changes only on an accepted request (`req_valid` and `req_ready` both 1).
- R8: `last_iter` is 1 exactly while the presented address is the Nth of a loop of count N.
- R9: With the reload bit set, acceptance of the Nth request restarts the count at N, and `req_ready` stays 1.
- R10: With the reload bit clear, after the Nth request is accepted `req_ready` stays 0 and the address holds, whatever `req_valid` does.
- R11: A loaded count of 0 leaves `req_ready` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Load all configuration fields and restart the offset |
| cfg_base | input | AW | Buffer base address |
| cfg_len | input | AW | Buffer length (circular) or FFT size (bit-reversed) |
| cfg_step | input | AW | Signed step, two's complement |
| cfg_mode | input | 2 | 0 linear, 1 circular, 2 bit-reversed, 3 linear |
| cfg_count | input | CW | Iterations per loop |
| cfg_reload | input | 1 | 1 restarts the count after the last pass, 0 halts |
| req_valid | input | 1 | Request for an address |
| req_ready | output | 1 | Unit can accept a request this cycle |
| addr_out | output | AW | Address for the current request |
| last_iter | output | 1 | Current address is the last pass of the loop |

## Verification
A corrupt offset shows up on `addr_out` in the cycle after the faulty update, because the address comes combinationally from the base and offset registers. A wrong wrap compare or a wrong carry direction therefore changes the very next sampled address. A faulty iteration count shows up as `last_iter` on the wrong row, or as a `req_ready` that drops or fails to drop on the cycle after the final accept. Every sequence begins with a fresh configuration, so one fault cannot hide behind state left over from another mode.

// File: rtl/agu_pkg.sv
package agu_pkg;
  typedef enum logic [1:0] {
    AGU_LIN     = 2'd0,
    AGU_CIRC    = 2'd1,
    AGU_BREV    = 2'd2,
    AGU_LIN_ALT = 2'd3
  } agu_mode_e;
endpackage

// File: rtl/agu_rst_sync.sv
module agu_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sh_q[STAGES-1];
endmodule

// File: rtl/agu_next_off.sv
module agu_next_off
  import agu_pkg::*;
#(
  parameter int AW = 16
) (
  input  agu_mode_e         mode,
  input  logic [AW-1:0]     off,
  input  logic [AW-1:0]     len,
  input  logic [AW-1:0]     step,
  output logic [AW-1:0]     nxt
);
  logic [AW-1:0] lin_nxt;
  logic [AW-1:0] circ_nxt;
  logic [AW-1:0] brev_nxt;

  // linear post-increment
  assign lin_nxt = off + step;

  // circular: one extra bit so that sign and overflow stay visible
  logic signed [AW:0] s_sum;
  logic signed [AW:0] s_len;
  logic signed [AW:0] s_wrap;

  assign s_len = $signed({1'b0, len});
  assign s_sum = $signed({1'b0, off}) + $signed({step[AW-1], step});

  always_comb begin
    s_wrap = s_sum;
    if (s_sum[AW])          s_wrap = s_sum + s_len;
    else if (s_sum >= s_len) s_wrap = s_sum - s_len;
  end

  assign circ_nxt = s_wrap[AW-1:0];

  // bit-reversed: mirror, add, mirror back
  logic [AW-1:0] half;
  logic [AW-1:0] off_m;
  logic [AW-1:0] half_m;
  logic [AW-1:0] sum_m;

  assign half = len >> 1;

  for (genvar i = 0; i < AW; i++) begin : g_mirror
    assign off_m[i]    = off[AW-1-i];
    assign half_m[i]   = half[AW-1-i];
    assign brev_nxt[i] = sum_m[AW-1-i];
  end

  assign sum_m = off_m + half_m;

  always_comb begin
    case (mode)
      AGU_CIRC: nxt = circ_nxt;
      AGU_BREV: nxt = brev_nxt;
      default:  nxt = lin_nxt;
    endcase
  end
endmodule

// File: rtl/agu_loop_ctr.sv
module agu_loop_ctr #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld,
  input  logic [CW-1:0] ld_cnt,
  input  logic          ld_reload,
  input  logic          fire,
  output logic          last,
  output logic          halted
);
  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] rem_q, rem_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          rl_q, rl_d;
  logic          halt_q, halt_d;
  logic          at_end;

  assign at_end = (rem_q == ONE);

  always_comb begin
    rem_d  = rem_q;
    cnt_d  = cnt_q;
    rl_d   = rl_q;
    halt_d = halt_q;
    if (ld) begin
      rem_d  = ld_cnt;
      cnt_d  = ld_cnt;
      rl_d   = ld_reload;
      halt_d = (ld_cnt == '0);
    end else if (fire) begin
      if (at_end) begin
        if (rl_q) begin
          rem_d = cnt_q;
        end else begin
          rem_d  = '0;
          halt_d = 1'b1;
        end
      end else begin
        rem_d = rem_q - ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      cnt_q  <= '0;
      rl_q   <= 1'b0;
      halt_q <= 1'b1;
    end else begin
      rem_q  <= rem_d;
      cnt_q  <= cnt_d;
      rl_q   <= rl_d;
      halt_q <= halt_d;
    end
  end

  assign last   = at_end && !halt_q;
  assign halted = halt_q;

  // R9
  reload_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && last && rl_q && !ld) |=> (rem_q == $past(cnt_q)) && !halted);

  // R10
  stop_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && last && !rl_q && !ld) |=> halted);

  // R11
  zero_count_halts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld && ld_cnt == '0) |=> halted && !last);
endmodule

// File: rtl/dsp_agu.sv
module dsp_agu
  import agu_pkg::*;
#(
  parameter int AW         = 16,
  parameter int CW         = 16,
  parameter int RST_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [AW-1:0] cfg_base,
  input  logic [AW-1:0] cfg_len,
  input  logic [AW-1:0] cfg_step,
  input  logic [1:0]    cfg_mode,
  input  logic [CW-1:0] cfg_count,
  input  logic          cfg_reload,
  input  logic          req_valid,
  output logic          req_ready,
  output logic [AW-1:0] addr_out,
  output logic          last_iter
);
  logic srst_n;

  agu_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  logic [AW-1:0] base_q, base_d;
  logic [AW-1:0] len_q,  len_d;
  logic [AW-1:0] step_q, step_d;
  agu_mode_e     mode_q, mode_d;
  logic [AW-1:0] off_q,  off_d;
  logic [AW-1:0] off_step;
  logic          fire;
  logic          ctr_last;
  logic          ctr_halted;

  assign req_ready = !ctr_halted && !cfg_we;
  assign fire      = req_valid && req_ready;

  agu_next_off #(.AW(AW)) u_next (
    .mode (mode_q),
    .off  (off_q),
    .len  (len_q),
    .step (step_q),
    .nxt  (off_step)
  );

  agu_loop_ctr #(.CW(CW)) u_loop (
    .clk       (clk),
    .rst_n     (srst_n),
    .ld        (cfg_we),
    .ld_cnt    (cfg_count),
    .ld_reload (cfg_reload),
    .fire      (fire),
    .last      (ctr_last),
    .halted    (ctr_halted)
  );

  always_comb begin
    base_d = base_q;
    len_d  = len_q;
    step_d = step_q;
    mode_d = mode_q;
    off_d  = off_q;
    if (cfg_we) begin
      base_d = cfg_base;
      len_d  = cfg_len;
      step_d = cfg_step;
      mode_d = agu_mode_e'(cfg_mode);
      off_d  = '0;
    end else if (fire) begin
      off_d  = off_step;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      base_q <= '0;
      len_q  <= '0;
      step_q <= '0;
      mode_q <= AGU_LIN;
      off_q  <= '0;
    end else begin
      base_q <= base_d;
      len_q  <= len_d;
      step_q <= step_d;
      mode_q <= mode_d;
      off_q  <= off_d;
    end
  end

  assign addr_out  = base_q + off_q;
  assign last_iter = ctr_last && !cfg_we;

  // R2
  cfg_restart_chk: assert property (@(posedge clk) disable iff (!srst_n)
    cfg_we |=> (addr_out == $past(cfg_base)));

  // R7
  offset_hold_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (!fire && !cfg_we) |=> $stable(off_q));

  // R4
  circ_in_range_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (mode_q == AGU_CIRC && fire && off_q < len_q) |=> (off_q < len_q));

  // R10
  halted_no_move_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (ctr_halted && !cfg_we) |=> $stable(addr_out) && !req_ready);
endmodule

// File: tb/tb_dsp_agu.sv
module tb_dsp_agu;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 5000;

  typedef struct packed {
    logic        we;
    logic [15:0] base;
    logic [15:0] len;
    logic [15:0] step;
    logic [1:0]  mode;
    logic [15:0] cnt;
    logic        rl;
    logic        vld;
    logic [15:0] ea;
    logic        el;
    logic        er;
    logic        ca;
    logic [3:0]  rq;
  } row_t;

  localparam int NROWS = 37;
  localparam row_t TBL [NROWS] = '{
    // linear, step 3, count 4, reload (R2 R3 R8 R9 R7)
    '{1'b1,16'h0100,16'h0000,16'h0003,2'd0,16'd4,1'b1,1'b0,16'h0000,1'b0,1'b0,1'b0,4'd2},
    '{1'b0,16'h0,16'h0,16'h0,2'd0,16'd0,1'b0,1'b1,16'h0100,1'b0,1'b1,1'b1,4'd2},
    '{1'b0,16'h0,16'h0,16'h0,2'd0,16'd0,1'b0,1'b1,16'h0103,1'b0,1'b1,1'b1,4'd3},
    '{1'b0,16'h0,16'h0,16'h0,2'd0,16'd0,1'b0,1'b1,16'h0106,1'b0,1'b1,1'b1,4'd3},
    '{1'b0,16'h0,16'h0,16'h0,2'd0,16'd0,1'b0,1'b1,16'h0109,1'b1,1'b1,1'b1,4'd8},
    '{1'b0,16'h0,16'h0,16'h0,2'd0,16'd0,1'b0,1'b1,16'h010C,1'b0,1'b1,1'b1,4'd9},
    '{1'b0,16'h0,16'h0,16'h0,2'd0,16'd0,1'b0,1'b0,16'h010F,1'b0,1'b1,1'b1,4'd7},
    '{1'b0,16'h0,16'h0,16'h0,2'd0,16'd0,1'b0,1'b1,16'h010F,1'b0,1'b1,1'b1,4'd7},
    // circular, len 5, step 2 (R4)
    '{1'b1,16'h0200,16'h0005,16'h0002,2'd1,16'd10,1'b0,1'b0,16'h0000,1'b0,1'b0,1'b0,4'd2},
    '{1'b0,16'h0,16'h0,16'h0,2'd0,16'd0,1'b0,1'b1,16'h0200,1'b0,1'b1,1'b1,4'd2},
    '{1'b0,16'h0,16'h0,16'h0,2'd0,16'd0,1'b0,1'b1,16'h0202,1'b0,1'b1,1'b1,4'd4},
    '{1'b0,16'h0,16'h0,16'h0,2'd0,16'd0,1'b0,1'b1,16'h0204,1'b0,1'b1,1'b1,4'd4},
    '{1'b0,16'h0,16'h0,16'h0,2'd0,16'd0,1'b0,1'b1,16'h0201,1'b0,1'b1,1'b1,4'd4},
    '{1'b0,16'h0,16'h0,16'h0,2'd0,16'd0,1'b0,1'b1,16'h0203,1'b0,1'b1,1'b1,4'd4},
    '{1'b0,16'h0,16'h0,16'h0,2'd0,16'd0,1'b0,1'b1,16'h0200,1'b0,1'b1,1'b1,4'd4},
    // circular, len 6, step -4, count 3, halt (R5 R8 R10)
    '{1'b1,16'h0300,16'h0006,16'hFFFC,2'd1,16'd3,1'b0,1'b0,16'h0000,1'b0,1'b0,1'b0,4'd2},
    '{1'b0,16'h0,16'h0,16'h0,2'd0,16'd0,1'b0,1'b1,16'h0300,1'b0,1'b1,1'b1,4'd5},
    '{1'b0,16'h0,16'h0,16'h0,2'd0,16'd0,1'b0,1'b1,16'h0302,1'b0,1'b1,1'b1,4'd5},
    '{1'b0,16'h0,16'h0,16'h0,2'd0,16'd0,1'b0,1'b1,16'h0304,1'b1,1'b1,1'b1,4'd8},
    '{1'b0,16'h0,16'h0,16'h0,2'd0,16'd0,1'b0,1'b1,16'h0300,1'b0,1'b0,1'b1,4'd10},
    '{1'b0,16'h0,16'h0,16'h0,2'd0,16'd0,1'b0,1'b1,16'h0300,1'b0,1'b0,1'b1,4'd10},
    // bit-reversed, size 8, step ignored, reload (R6 R9)
    '{1'b1,16'h0400,16'h0008,16'h0007,2'd2,16'd8,1'b1,1'b0,16'h0000,1'b0,1'b0,1'b0,4'd2},
    '{1'b0,16'h0,16'h0,16'h0,2'd0,16'd0,1'b0,1'b1,16'h0400,1'b0,1'b1,1'b1,4'd6},
    '{1'b0,16'h0,16'h0,16'h0,2'd0,16'd0,1'b0,1'b1,16'h0404,1'b0,1'b1,1'b1,4'd6},
    '{1'b0,16'h0,16'h0,16'h0,2'd0,16'd0,1'b0,1'b1,16'h0402,1'b0,1'b1,1'b1,4'd6},
    '{1'b0,16'h0,16'h0,16'h0,2'd0,16'd0,1'b0,1'b1,16'h0406,1'b0,1'b1,1'b1,4'd6},
    '{1'b0,16'h0,16'h0,16'h0,2'd0,16'd0,1'b0,1'b1,16'h0401,1'b0,1'b1,1'b1,4'd6},
    '{1'b0,16'h0,16'h0,16'h0,2'd0,16'd0,1'b0,1'b1,16'h0405,1'b0,1'b1,1'b1,4'd6},
    '{1'b0,16'h0,16'h0,16'h0,2'd0,16'd0,1'b0,1'b1,16'h0403,1'b0,1'b1,1'b1,4'd6},
    '{1'b0,16'h0,16'h0,16'h0,2'd0,16'd0,1'b0,1'b1,16'h0407,1'b1,1'b1,1'b1,4'd8},
    '{1'b0,16'h0,16'h0,16'h0,2'd0,16'd0,1'b0,1'b1,16'h0400,1'b0,1'b1,1'b1,4'd9},
    // count zero (R11)
    '{1'b1,16'h0500,16'h0000,16'h0001,2'd0,16'd0,1'b1,1'b0,16'h0000,1'b0,1'b0,1'b0,4'd2},
    '{1'b0,16'h0,16'h0,16'h0,2'd0,16'd0,1'b0,1'b1,16'h0500,1'b0,1'b0,1'b1,4'd11},
    // mode 3, step -1, count 2, halt (R3 R10)
    '{1'b1,16'h0010,16'h0000,16'hFFFF,2'd3,16'd2,1'b0,1'b0,16'h0000,1'b0,1'b0,1'b0,4'd2},
    '{1'b0,16'h0,16'h0,16'h0,2'd0,16'd0,1'b0,1'b1,16'h0010,1'b0,1'b1,1'b1,4'd3},
    '{1'b0,16'h0,16'h0,16'h0,2'd0,16'd0,1'b0,1'b1,16'h000F,1'b1,1'b1,1'b1,4'd8},
    '{1'b0,16'h0,16'h0,16'h0,2'd0,16'd0,1'b0,1'b1,16'h000E,1'b0,1'b0,1'b1,4'd10}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [15:0] cfg_base, cfg_len, cfg_step, cfg_count;
  logic [1:0]  cfg_mode;
  logic        cfg_reload;
  logic        req_valid;
  logic        req_ready;
  logic [15:0] addr_out;
  logic        last_iter;

  int checks   = 0;
  int failures = 0;
  logic done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dsp_agu dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_base   (cfg_base),
    .cfg_len    (cfg_len),
    .cfg_step   (cfg_step),
    .cfg_mode   (cfg_mode),
    .cfg_count  (cfg_count),
    .cfg_reload (cfg_reload),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .addr_out   (addr_out),
    .last_iter  (last_iter)
  );

  task automatic check(input string tag, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      finish_run();
    end
  end

  initial begin
    rst_n      = 1'b0;
    cfg_we     = 1'b0;
    cfg_base   = '0;
    cfg_len    = '0;
    cfg_step   = '0;
    cfg_mode   = '0;
    cfg_count  = '0;
    cfg_reload = 1'b0;
    req_valid  = 1'b1;

    // R1: state during reset
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", "ready", {15'd0, req_ready}, 16'd0);
    check("R1", "last",  {15'd0, last_iter}, 16'd0);
    check("R1", "addr",  addr_out, 16'h0000);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    // R11: nothing loaded yet, valid held high, still not ready
    @(negedge clk);
    check("R11", "ready before load", {15'd0, req_ready}, 16'd0);

    for (int i = 0; i < NROWS; i++) begin
      row_t r;
      r = TBL[i];
      cfg_we     = r.we;
      cfg_base   = r.base;
      cfg_len    = r.len;
      cfg_step   = r.step;
      cfg_mode   = r.mode;
      cfg_count  = r.cnt;
      cfg_reload = r.rl;
      req_valid  = r.vld;
      #1;
      check($sformatf("R%0d row%0d", r.rq, i), "ready", {15'd0, req_ready}, {15'd0, r.er});
      if (r.ca) begin
        check($sformatf("R%0d row%0d", r.rq, i), "addr", addr_out, r.ea);
        check($sformatf("R%0d row%0d", r.rq, i), "last", {15'd0, last_iter}, {15'd0, r.el});
      end else begin
        check($sformatf("R%0d row%0d", r.rq, i), "last in cfg", {15'd0, last_iter}, 16'd0);
      end
      @(negedge clk);
    end

    // R2: reconfigure in the middle of a loop, offset restarts at base
    cfg_we = 1'b1; cfg_base = 16'h0700; cfg_len = 16'h0004; cfg_step = 16'h0001;
    cfg_mode = 2'd1; cfg_count = 16'd5; cfg_reload = 1'b0; req_valid = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
    repeat (2) @(negedge clk);
    #1 check("R4", "circ mid", addr_out, 16'h0702);
    cfg_we = 1'b1; cfg_base = 16'h0800;
    @(negedge clk);
    cfg_we = 1'b0; req_valid = 1'b0;
    #1 check("R2", "restart at new base", addr_out, 16'h0800);

    // R1: asynchronous reset in the middle of operation
    req_valid = 1'b1;
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1", "async ready", {15'd0, req_ready}, 16'd0);
    check("R1", "async addr",  addr_out, 16'h0000);

    done = 1'b1;
    finish_run();
  end
endmodule